// File: doc/BRIEF.md
# Sixteen-Register Pointer File

This block holds sixteen 16-bit general registers and two 4-bit selectors. The P selector picks the register that acts as the program counter, and the X selector picks the register that acts as the data pointer. Any of the sixteen registers can take either role. A 4-bit command input, together with a 4-bit register index N, steps a register up or down, reads or writes one byte of a register, moves a pointer, or saves and restores the packed selector pair.

The block does not touch memory. A byte that has to be stored appears on `dout` in the same cycle as its command. A byte fetched from memory for a restore is presented on `din`. The three address registers a memory stage needs are visible at all times on `pc_val`, `dp_val` and `sp_val`. All state changes take effect on the rising clock edge. Reset is synchronous and active low.

Top module: `ptr_regfile`

## Requirements
- R1: While `rst_n` is low, every register, P, X, T and IE are cleared to 0 at the clock edge.
- R2: Command 1 adds 1 to register N and command 2 subtracts 1 from it. Both wrap modulo 2^16, so FFFF+1 gives 0000 and 0000-1 gives FFFF.
- R3: Command 3 drives the low byte of register N onto `dout`, and command 4 drives its high byte, in the same cycle and with no clock edge in between. Any command other than 3, 4 and 9 drives `dout` to 00.
- R4: Command 5 writes `din` into the low byte of register N, and command 6 writes `din` into its high byte. The other byte of that register is left unchanged.
- R5: Command 7 loads N into P and command 8 loads N into X. Afterwards `pc_val` and `dp_val` show the newly selected registers.
- R6: Command 9 (save) drives the packed byte {X,P}, with X in bits 7:4 and P in bits 3:0, onto `dout` in the same cycle. At the edge it copies that byte into T, copies P into X, and subtracts 1 from register 2.
- R7: Command 10 (restore) and command 11 (restore with interrupts off) load X from `din[7:4]` and P from `din[3:0]`, and add 1 to the register that X selected before the command. Command 10 sets IE to 1 and command 11 clears it to 0.
- R8: Command 12 copies the whole of register N into the register selected by X. When N equals X, nothing changes.
- R9: Command 0, and the unused codes 13 to 15, leave every register, P, X, T and IE unchanged.
- R10: When a command reads and writes the same register, it uses the value from before the edge. For example, a save while X is 2 reports X as 2 in the pushed byte, and a restore increments the old X register even when `din` names a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 4 | Command code |
| n_idx | input | 4 | Register index N, or the new value for P/X |
| din | input | 8 | Byte to write or restore |
| dout | output | 8 | Byte read out, or the packed {X,P} for a save |
| p_sel | output | 4 | Current P selector |
| x_sel | output | 4 | Current X selector |
| pc_val | output | 16 | Register selected by P |
| dp_val | output | 16 | Register selected by X |
| sp_val | output | 16 | Register 2 (save stack pointer) |
| t_val | output | 8 | Saved pointer byte T |
| ie | output | 1 | Interrupt-enable bit |

## Verification
The `dout` results of byte reads and of a save are combinational, so the bench checks them 1 ns after it drives the command, before the next rising edge. Every other result comes from one register stage and is due on the first rising edge after the command. The bench checks it 1 ns after that edge. A reference model inside the bench is updated from values taken before the edge, which covers the read-before-write cases. The bench writes a distinct value into every register and reads each one back, and it sweeps P and X through all sixteen positions.

// File: rtl/ptr_regfile.sv
module ptr_regfile #(
  parameter int NREG = 16,
  parameter int W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               cmd,
  input  logic [$clog2(NREG)-1:0]  n_idx,
  input  logic [W/2-1:0]           din,
  output logic [W/2-1:0]           dout,
  output logic [$clog2(NREG)-1:0]  p_sel,
  output logic [$clog2(NREG)-1:0]  x_sel,
  output logic [W-1:0]             pc_val,
  output logic [W-1:0]             dp_val,
  output logic [W-1:0]             sp_val,
  output logic [W/2-1:0]           t_val,
  output logic                     ie
);
  localparam int IDX  = $clog2(NREG);
  localparam int HALF = W / 2;
  localparam logic [IDX-1:0] SPR = IDX'(2);

  localparam logic [3:0] C_NOP = 4'd0,  C_INC = 4'd1,  C_DEC = 4'd2,
                         C_GLO = 4'd3,  C_GHI = 4'd4,  C_PLO = 4'd5,
                         C_PHI = 4'd6,  C_SETP = 4'd7, C_SETX = 4'd8,
                         C_SAVE = 4'd9, C_RET = 4'd10, C_DIS = 4'd11,
                         C_COPY = 4'd12;

  logic [W-1:0]    regs [NREG];
  logic [IDX-1:0]  p_q, x_q;
  logic [HALF-1:0] t_q;
  logic            ie_q;

  assign p_sel  = p_q;
  assign x_sel  = x_q;
  assign pc_val = regs[p_q];
  assign dp_val = regs[x_q];
  assign sp_val = regs[SPR];
  assign t_val  = t_q;
  assign ie     = ie_q;

  always_comb begin
    case (cmd)
      C_GLO:   dout = regs[n_idx][HALF-1:0];
      C_GHI:   dout = regs[n_idx][W-1:HALF];
      C_SAVE:  dout = HALF'({x_q, p_q});
      default: dout = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      p_q  <= '0;
      x_q  <= '0;
      t_q  <= '0;
      ie_q <= 1'b0;
    end else begin
      case (cmd)
        C_INC:  regs[n_idx] <= regs[n_idx] + 1'b1;
        C_DEC:  regs[n_idx] <= regs[n_idx] - 1'b1;
        C_PLO:  regs[n_idx][HALF-1:0] <= din;
        C_PHI:  regs[n_idx][W-1:HALF] <= din;
        C_SETP: p_q <= n_idx;
        C_SETX: x_q <= n_idx;
        C_SAVE: begin
          t_q       <= HALF'({x_q, p_q});
          x_q       <= p_q;
          regs[SPR] <= regs[SPR] - 1'b1;
        end
        C_RET, C_DIS: begin
          x_q       <= din[2*IDX-1:IDX];
          p_q       <= din[IDX-1:0];
          regs[x_q] <= regs[x_q] + 1'b1;
          ie_q      <= (cmd == C_RET);
        end
        C_COPY: regs[x_q] <= regs[n_idx];
        default: ;
      endcase
    end
  end

  AST_INC_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_INC && n_idx == p_q) |=> pc_val == $past(pc_val) + 1'b1); // R2
  AST_SETP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SETP) |=> p_sel == $past(n_idx)); // R5
  AST_SAVE_XP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SAVE) |=> (x_sel == $past(p_sel)) && (t_val == $past(dout))); // R6
  AST_SAVE_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_SAVE) |=> sp_val == $past(sp_val) - 1'b1); // R6
  AST_RET_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RET) |=> ie); // R7
  AST_DIS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_DIS) |=> !ie); // R7
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_NOP) |=> $stable(p_sel) && $stable(x_sel) && $stable(ie) && $stable(t_val)); // R9
endmodule

// File: tb/tb_ptr_regfile.sv
module tb_ptr_regfile;
  logic clk = 0, rst_n = 0;
  logic [3:0] cmd = 0, n_idx = 0;
  logic [7:0] din = 0;
  logic [7:0] dout, t_val;
  logic [3:0] p_sel, x_sel;
  logic [15:0] pc_val, dp_val, sp_val;
  logic ie;

  int checks = 0, fails = 0;
  logic [15:0] m_r [16];
  logic [3:0] m_p, m_x;
  logic [7:0] m_t;
  logic m_ie;

  always #2 clk = ~clk;

  ptr_regfile dut (.clk(clk), .rst_n(rst_n), .cmd(cmd), .n_idx(n_idx), .din(din),
    .dout(dout), .p_sel(p_sel), .x_sel(x_sel), .pc_val(pc_val), .dp_val(dp_val),
    .sp_val(sp_val), .t_val(t_val), .ie(ie));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " p"}, {12'd0, p_sel}, {12'd0, m_p});
    chk({tag, " x"}, {12'd0, x_sel}, {12'd0, m_x});
    chk({tag, " pc"}, pc_val, m_r[m_p]);
    chk({tag, " dp"}, dp_val, m_r[m_x]);
    chk({tag, " sp"}, sp_val, m_r[2]);
    chk({tag, " t"}, {8'd0, t_val}, {8'd0, m_t});
    chk({tag, " ie"}, {15'd0, ie}, {15'd0, m_ie});
  endtask

  task automatic op(string tag, logic [3:0] c, logic [3:0] n, logic [7:0] d);
    logic [7:0] exp_out;
    logic [15:0] old_n, old_x, old_2;
    logic [3:0] old_p, old_xi;
    @(negedge clk);
    cmd = c; n_idx = n; din = d;
    #1;
    old_n = m_r[n]; old_x = m_r[m_x]; old_2 = m_r[2];
    old_p = m_p; old_xi = m_x;
    case (c)
      4'd3: exp_out = old_n[7:0];
      4'd4: exp_out = old_n[15:8];
      4'd9: exp_out = {old_xi, old_p};
      default: exp_out = 8'h00;
    endcase
    chk({tag, " dout"}, {8'd0, dout}, {8'd0, exp_out});
    @(posedge clk);
    case (c)
      4'd1: m_r[n] = old_n + 16'd1;
      4'd2: m_r[n] = old_n - 16'd1;
      4'd5: m_r[n][7:0] = d;
      4'd6: m_r[n][15:8] = d;
      4'd7: m_p = n;
      4'd8: m_x = n;
      4'd9: begin m_t = {old_xi, old_p}; m_x = old_p; m_r[2] = old_2 - 16'd1; end
      4'd10, 4'd11: begin
        m_r[old_xi] = old_x + 16'd1; m_x = d[7:4]; m_p = d[3:0]; m_ie = (c == 4'd10);
      end
      4'd12: m_r[old_xi] = old_n;
      default: ;
    endcase
    #1;
    chk_state(tag);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_r[i] = 16'h0;
    m_p = 0; m_x = 0; m_t = 0; m_ie = 0;
    repeat (3) @(posedge clk);
    #1;
    chk_state("R1 reset");
    rst_n = 1;
    // R4: fill each register with a computed pattern, both halves
    for (int i = 0; i < 16; i++) begin
      op("R4 plo", 4'd5, 4'(i), 8'((i * 37 + 5) & 8'hFF));
      op("R4 phi", 4'd6, 4'(i), 8'((i * 19) ^ 8'hA5));
    end
    // R4: rewrite low only, high kept
    op("R4 plo only", 4'd5, 4'd7, 8'h3C);
    // R3: read back every register
    for (int i = 0; i < 16; i++) begin
      op("R3 glo", 4'd3, 4'(i), 8'h00);
      op("R3 ghi", 4'd4, 4'(i), 8'h00);
    end
    // R5: sweep P and X
    for (int i = 0; i < 16; i++) begin
      op("R5 setp", 4'd7, 4'(i), 8'h00);
      op("R5 setx", 4'd8, 4'(15 - i), 8'h00);
    end
    // R2: wrap both ways
    op("R2 phi", 4'd6, 4'd9, 8'hFF);
    op("R2 plo", 4'd5, 4'd9, 8'hFF);
    op("R2 inc wrap", 4'd1, 4'd9, 8'h00);
    op("R2 dec wrap", 4'd2, 4'd9, 8'h00);
    op("R2 dec", 4'd2, 4'd4, 8'h00);
    op("R2 inc", 4'd1, 4'd4, 8'h00);
    op("R2 setp", 4'd7, 4'd9, 8'h00);
    op("R2 inc pc", 4'd1, 4'd9, 8'h00);
    // R6 / R10: save with X = 2 and P = 5
    op("R6 setx", 4'd8, 4'd2, 8'h00);
    op("R6 setp", 4'd7, 4'd5, 8'h00);
    op("R6 R10 save x2", 4'd9, 4'd0, 8'h00);
    op("R6 save", 4'd9, 4'd0, 8'h00);
    // R7 / R10: restore increments old X register
    op("R7 setx", 4'd8, 4'd11, 8'h00);
    op("R7 R10 ret", 4'd10, 4'd0, 8'h3B);
    op("R7 dis", 4'd11, 4'd0, 8'hC6);
    op("R7 ret again", 4'd10, 4'd0, 8'h21);
    op("R7 dis self", 4'd11, 4'd0, 8'h11);
    // R8: copy N into X register, and N == X
    op("R8 setx", 4'd8, 4'd14, 8'h00);
    op("R8 copy", 4'd12, 4'd3, 8'h00);
    op("R8 copy self", 4'd12, 4'd14, 8'h00);
    op("R8 glo", 4'd3, 4'd14, 8'h00);
    // R9: no-op and unused codes leave state alone
    op("R9 nop", 4'd0, 4'd6, 8'hFF);
    op("R9 code13", 4'd13, 4'd6, 8'hFF);
    op("R9 code15", 4'd15, 4'd2, 8'h77);
    for (int i = 0; i < 16; i++) op("R9 readback", 4'd4, 4'(i), 8'h00);
    // R1: reset again clears everything
    @(negedge clk);
    rst_n = 0; cmd = 0;
    @(posedge clk);
    for (int i = 0; i < 16; i++) m_r[i] = 16'h0;
    m_p = 0; m_x = 0; m_t = 0; m_ie = 0;
    #1;
    chk_state("R1 reset again");
    rst_n = 1;
    for (int i = 0; i < 16; i++) op("R1 cleared", 4'd3, 4'(i), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule